// File: doc/BRIEF.md
# Four-Channel Compare PWM Timer

The block is a pulse-width timer built around one up-counter. Each clock the counter can advance by one. A 4-bit scale field picks a right shift of the count, and the low bits of the shifted value form the "scaled count". Four compare channels test the scaled count against their own threshold. Each channel drives one PWM output and one interrupt line from a pending flag.

A configuration word selects how the counter runs: continuously, or for a single period that stops the timer by itself. It can also restart the counter when channel 0 matches, which sets the period from channel 0's threshold. Per channel, the word can fold the comparison into a centre-aligned shape, or gang the channel with its neighbour so the output only covers the gap between the two thresholds. It also chooses how the pending flags behave. They can follow the compare, latch until the end of the period, or stay set against software writes. Software reaches everything through a simple single-cycle register bus. A write completes in the cycle it is presented, with no back-pressure, and read data is a combinational function of the address.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted, all PWM outputs and interrupt lines are 0 and the configuration word reads 0. After reset the counter starts at 0.
- R2: The counter (offset 0x08, read/write) advances by one per clock while configuration bit 12 (continuous) or bit 13 (single period) is set. It holds its value when both bits are clear. A bus write to 0x08 loads it.
- R3: When the counter holds its all-ones value while running, it becomes 0 on the next clock.
- R4: With configuration bit 9 set, a running counter goes to 0 instead of incrementing in the cycle after the scaled count is at or above the channel 0 threshold. This uses the plain, unfolded comparison.
- R5: Bit 13 clears itself when a period ends, either by wrap or by the bit-9 restart, after which the counter holds. Bit 12 stays set across period ends.
- R6: The scaled count (offset 0x10, read-only) is the counter shifted right by configuration bits 3:0, keeping the compare width. Channel i hits when its compare value is at or above its threshold, which sits at offset 0x20+4*i. PWM output i shows the result one clock later.
- R7: When configuration bit 16+i is set and the top bit of the scaled count is 1, channel i compares the bitwise inverse of the scaled count.
- R8: When configuration bit 24+i is set, PWM output i is high only if channel i hits and channel (i+1) mod 4 does not.
- R9: With bits 8 and 10 clear, pending flag i equals the channel i hit of the previous clock. The flags appear on the interrupt lines and in configuration bits 31:28.
- R10: With bit 10 (latch) set, a pending flag that has been set stays set until the clock on which a period ends.
- R11: With bit 8 (sticky) set, a pending flag that has been set stays set, and configuration writes do not change any flag.
- R12: A configuration write made while bit 8 is clear loads the pending flags from write bits 31:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_o | output | 4 | Registered PWM outputs, one per channel |
| irq_o | output | 4 | Pending flags driven as interrupt lines |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit compare width. This makes every counter value cheap to visit, so the compare, fold and gang logic can be swept over all 256 counts for several scales and threshold sets. A natural wrap then takes only a few hundred clocks. The narrow compare width puts the centre-fold bit at bit 3, so short restart periods cross it. That allows the latched pending flags to be checked across a full period end.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int NCH     = 4;
  localparam int SCALE_W = 4;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_CFG    = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_SCALED = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_THR0   = 6'h20;

  typedef struct packed {
    logic [NCH-1:0]     gang;
    logic [NCH-1:0]     center;
    logic               run_once;
    logic               run_cont;
    logic               latch_ip;
    logic               zero_rst;
    logic               sticky;
    logic [SCALE_W-1:0] scale;
  } cfg_t;
endpackage

// File: rtl/pwm_chan_cmp.sv
`timescale 1ns/1ps
module pwm_chan_cmp #(
  parameter int CMP_W = 8
) (
  input  logic [CMP_W-1:0] scaled,
  input  logic             center,
  input  logic [CMP_W-1:0] thresh,
  output logic             hit
);
  logic [CMP_W-1:0] folded;

  // centre mode reflects the upper half of the ramp to make a triangle
  always_comb begin
    folded = (center && scaled[CMP_W-1]) ? ~scaled : scaled;
    hit    = (folded >= thresh);
  end
endmodule

// File: rtl/pwm_count_core.sv
`timescale 1ns/1ps
module pwm_count_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               zero_rst,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   thresh0,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled,
  output logic               cyc_end
);
  logic [CNT_W-1:0] shifted;
  logic             at_top;
  logic             restart;

  always_comb begin
    shifted = count >> scale;
    scaled  = shifted[CMP_W-1:0];
    at_top  = (count == {CNT_W{1'b1}});
    restart = zero_rst && (scaled >= thresh0);
    cyc_end = run && (at_top || restart);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load)     count <= load_val;
    else if (cyc_end)  count <= '0;
    else if (run)      count <= count + 1'b1;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !cyc_end) |=> (count == CNT_W'($past(count) + 1'b1)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && at_top) |=> (count == '0));
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && zero_rst && (scaled >= thresh0)) |=> (count == '0));
endmodule

// File: rtl/pwm_reg_file.sv
`timescale 1ns/1ps
module pwm_reg_file
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CMP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        cyc_end,
  input  logic [NCH-1:0]              hit,
  input  logic [CNT_W-1:0]            count,
  input  logic [CMP_W-1:0]            scaled,
  output cfg_t                        cfg,
  output logic [NCH-1:0][CMP_W-1:0]   thresh,
  output logic [NCH-1:0]              ip,
  output logic                        cnt_load,
  output logic [DATA_W-1:0]           rdata
);
  logic cfg_we;

  always_comb begin
    cfg_we   = wr && (addr == OFF_CFG);
    cnt_load = wr && (addr == OFF_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we) begin
      cfg.scale    <= wdata[3:0];
      cfg.sticky   <= wdata[8];
      cfg.zero_rst <= wdata[9];
      cfg.latch_ip <= wdata[10];
      cfg.run_cont <= wdata[12];
      cfg.run_once <= wdata[13];
      cfg.center   <= wdata[19:16];
      cfg.gang     <= wdata[27:24];
    end else if (cyc_end) begin
      cfg.run_once <= 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_thr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thresh[i] <= '0;
        else if (wr && (addr == ADDR_W'(OFF_THR0 + 4*i))) thresh[i] <= wdata[CMP_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= '0;
    end else if (cfg_we && !cfg.sticky) begin
      ip <= wdata[31:28];
    end else begin
      for (int i = 0; i < NCH; i++)
        ip[i] <= hit[i] | (ip[i] & (cfg.sticky | (cfg.latch_ip & ~cyc_end)));
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFF_CFG)
      rdata = {ip, cfg.gang, 4'b0, cfg.center, 2'b0, cfg.run_once, cfg.run_cont,
               1'b0, cfg.latch_ip, cfg.zero_rst, cfg.sticky, 4'b0, cfg.scale};
    else if (addr == OFF_COUNT)
      rdata = DATA_W'(count);
    else if (addr == OFF_SCALED)
      rdata = DATA_W'(scaled);
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(OFF_THR0 + 4*i)) rdata = DATA_W'(thresh[i]);
  end

  p_once_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !cfg_we) |=> !cfg.run_once);
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.sticky |=> ((ip & $past(ip)) == $past(ip)));
  p_ip_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg.sticky) |=> (ip == $past(wdata[31:28])));
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        pwm_o,
  output logic [3:0]        irq_o
);
  cfg_t                      cfg;
  logic [NCH-1:0][CMP_W-1:0] thresh;
  logic [NCH-1:0]            ip;
  logic [NCH-1:0]            hit;
  logic [NCH-1:0]            gated;
  logic                      cnt_load;
  logic [CNT_W-1:0]          count;
  logic [CMP_W-1:0]          scaled;
  logic                      cyc_end;

  pwm_reg_file #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cyc_end(cyc_end), .hit(hit), .count(count), .scaled(scaled),
    .cfg(cfg), .thresh(thresh), .ip(ip), .cnt_load(cnt_load), .rdata(bus_rdata)
  );

  pwm_count_core #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(cfg.run_cont | cfg.run_once),
    .zero_rst(cfg.zero_rst), .scale(cfg.scale), .thresh0(thresh[0]),
    .load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]),
    .count(count), .scaled(scaled), .cyc_end(cyc_end)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int NXT = (i + 1) % NCH;
      pwm_chan_cmp #(.CMP_W(CMP_W)) u_cmp (
        .scaled(scaled), .center(cfg.center[i]), .thresh(thresh[i]), .hit(hit[i])
      );
      // ganged: only the window between this threshold and the next one
      assign gated[i] = hit[i] & ~(cfg.gang[i] & hit[NXT]);

      p_gang_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gang[i] && hit[NXT]) |=> !pwm_o[i]);
      p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gang[i] |=> (pwm_o[i] == $past(hit[i])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= '0;
    else        pwm_o <= gated;
  end

  assign irq_o = ip;

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (pwm_o == '0 && irq_o == '0));
endmodule

// File: tb/pwm_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_tb_top;
  localparam int CNT_W = 8;
  localparam int CMP_W = 4;
  localparam logic [5:0] A_CFG = 6'h00, A_CNT = 6'h08, A_SCL = 6'h10, A_THR = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_timer #(.CNT_W(CNT_W), .CMP_W(CMP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [3:0] scl(input int c, input int sc);
    return 4'((c >> sc) & 15);
  endfunction

  function automatic logic hitf(input int c, input int sc, input bit cen, input int thr);
    logic [3:0] s;
    logic [3:0] v;
    s = scl(c, sc);
    v = (cen && s[3]) ? ~s : s;
    return (int'(v) >= thr);
  endfunction

  int thr_a[4] = '{3, 7, 9, 14};
  int thr_b[4] = '{2, 5, 9, 12};

  initial begin
    #(150000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  exp_h, exp_o;
    logic [3:0]  cen;
    logic [3:0]  gg;

    // R1: state while held in reset
    tick(3);
    chk("R1 pwm in reset", 32'(pwm_o), 0);
    chk("R1 irq in reset", 32'(irq_o), 0);
    bus_read(A_CFG, rd); chk("R1 cfg in reset", rd, 0);
    bus_read(A_CNT, rd); chk("R1 count in reset", rd, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);

    // R6 R7 R9: full count sweep, stopped timer
    for (int i = 0; i < 4; i++) bus_write(6'(A_THR + 4*i), 32'(thr_a[i]));
    bus_read(6'(A_THR + 4), rd); chk("R6 threshold readback", rd, 7);
    for (int sc = 0; sc < 6; sc++) begin
      for (int v = 0; v < 3; v++) begin
        cen = (v == 0) ? 4'h0 : (v == 1) ? 4'hF : 4'h5;
        bus_write(A_CFG, 32'(sc) | (32'(cen) << 16));
        for (int c = 0; c < 256; c++) begin
          bus_write(A_CNT, 32'(c));
          tick(1);
          for (int i = 0; i < 4; i++) exp_h[i] = hitf(c, sc, cen[i], thr_a[i]);
          chk("R6/R7 pwm sweep", 32'(pwm_o), 32'(exp_h));
          chk("R9 pending follows compare", 32'(irq_o), 32'(exp_h));
          bus_read(A_SCL, rd); chk("R6 scaled count", rd, 32'(scl(c, sc)));
        end
      end
    end

    // R8: ganged channels
    for (int i = 0; i < 4; i++) bus_write(6'(A_THR + 4*i), 32'(thr_b[i]));
    for (int p = 0; p < 3; p++) begin
      gg = (p == 0) ? 4'hF : (p == 1) ? 4'h5 : 4'h8;
      bus_write(A_CFG, 32'(gg) << 24);
      for (int c = 0; c < 16; c++) begin
        bus_write(A_CNT, 32'(c));
        tick(1);
        for (int i = 0; i < 4; i++) exp_h[i] = hitf(c, 0, 1'b0, thr_b[i]);
        for (int i = 0; i < 4; i++) exp_o[i] = exp_h[i] & ~(gg[i] & exp_h[(i+1)%4]);
        chk("R8 gang output", 32'(pwm_o), 32'(exp_o));
        chk("R9 pending ignores gang", 32'(irq_o), 32'(exp_h));
      end
    end

    // R2 R3 R5: continuous run and wrap
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 250);
    tick(4); bus_read(A_CNT, rd); chk("R2 holds when stopped", rd, 250);
    bus_write(A_CFG, 32'h1000);
    tick(5); bus_read(A_CNT, rd); chk("R2 advances", rd, 255);
    tick(1); bus_read(A_CNT, rd); chk("R3 wraps to zero", rd, 0);
    tick(3); bus_read(A_CNT, rd); chk("R3 after wrap", rd, 3);
    bus_read(A_CFG, rd); chk("R5 continuous stays set", rd & 32'h1000, 32'h1000);

    // R4: restart on channel 0 match, scale 1, threshold 5 -> period 11
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 0);
    bus_write(A_THR, 5);
    bus_write(A_CFG, 32'h1201);
    tick(10); bus_read(A_CNT, rd); chk("R4 reaches match", rd, 10);
    tick(1);  bus_read(A_CNT, rd); chk("R4 restart to zero", rd, 0);
    tick(4);  bus_read(A_CNT, rd); chk("R4 runs after restart", rd, 4);

    // R5: single period ending by restart
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 0);
    bus_write(A_CFG, 32'h2201);
    tick(11); bus_read(A_CNT, rd); chk("R5 single period end", rd, 0);
    bus_read(A_CFG, rd); chk("R5 single bit cleared", rd & 32'h2000, 0);
    tick(5); bus_read(A_CNT, rd); chk("R5 holds after single period", rd, 0);
    // R5: single period ending by wrap
    bus_write(A_CNT, 253);
    bus_write(A_CFG, 32'h2000);
    tick(3); bus_read(A_CNT, rd); chk("R5 single wrap", rd, 0);
    tick(2); bus_read(A_CNT, rd); chk("R5 holds after wrap", rd, 0);
    bus_read(A_CFG, rd); chk("R5 single bit cleared by wrap", rd & 32'h2000, 0);

    // R9 vs R10: thr0=12 restart (period 13), channel 1 centred thr 6
    bus_write(A_THR, 12);
    bus_write(A_THR + 4, 6);
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 0);
    bus_write(A_CFG, 32'h0002_1200);
    tick(11); chk("R9 pending drops without latch", 32'(irq_o[1]), 0);
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 0);
    bus_write(A_CFG, 32'h0002_1600);
    tick(11); chk("R10 pending latched in period", 32'(irq_o[1]), 1);
    tick(2);  chk("R10 cleared at period end", 32'(irq_o[1]), 0);
    tick(2);  chk("R10 stays clear", 32'(irq_o[1]), 0);

    // R11: sticky pending
    bus_write(A_CFG, 0);
    bus_write(A_CNT, 12);
    bus_write(A_CFG, 32'h100);
    tick(1); chk("R11 set by compare", 32'(irq_o[0]), 1);
    bus_write(A_CNT, 0);
    tick(2); chk("R11 held without compare", 32'(irq_o[0]), 1);
    bus_write(A_CFG, 32'h100);
    chk("R11 write cannot clear", 32'(irq_o[0]), 1);
    bus_write(A_CFG, 32'h0);
    chk("R11 write with sticky set ignored", 32'(irq_o[0]), 1);
    tick(1);
    bus_write(A_CFG, 32'h0);
    chk("R12 clear when not sticky", 32'(irq_o[0]), 0);

    // R12: load pending flags by write, held by latch mode while stopped
    for (int i = 0; i < 4; i++) bus_write(6'(A_THR + 4*i), 15);
    bus_write(A_CNT, 0);
    bus_write(A_CFG, 32'hA000_0400);
    chk("R12 flags loaded", 32'(irq_o), 32'hA);
    tick(3);
    chk("R12 flags held", 32'(irq_o), 32'hA);
    bus_read(A_CFG, rd); chk("R12 flags in cfg word", rd, 32'hA000_0400);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule